// File: doc/BRIEF.md
# Decoder Register Script Sequencer

After reset this block plays one of two built-in initialisation scripts into a video decoder. It drives a byte-level I2C master through a command stream and takes back one response for each command. A script entry is a register write, a wait counted in milliseconds, or an end marker. Every write goes to device write address 0x42, and every read to 0x43. When read-back is enabled, each write that can be checked is followed at once by a read of the same register, and the value read is compared with the value written.

The script is picked from the level on `script_sel` in the first cycle after reset: 0 runs the normal autodetect set-up and 1 runs the forced free-run colour-bar set-up. Both scripts start the same way. They wait, soft-reset the decoder, wait again, leave power-down, and set the analog bias. Both finish with the same driver, crystal and pixel-clock writes. Waits are counted in 1 ms ticks taken from `CLK_HZ`. The length of each wait is stored in the script entry, and the `DELAY_MS` parameter sets it.

The command stream follows valid/ready rules. `cmd_op` and `cmd_byte` are held steady while `cmd_valid` is high and `cmd_ready` is low. A command transfers on a cycle where both are high. Only one command is outstanding at a time, and no new command is raised until its response has arrived. The response is a one-cycle `rsp_valid` pulse with no ready signal: the block takes it in whatever cycle it comes. The master may stall `cmd_ready` for as long as it needs.

Top module: `i2c_init_sequencer`

## Requirements
- R1: While reset is held low, and in the first cycle after it is released, `done`, `error` and `cmd_valid` are all 0.
- R2: No command is issued until DELAY_MS×(CLK_HZ/1000) clock cycles after reset is released.
- R3: A write is sent as START, WRITE 0x42, WRITE register, WRITE data, STOP. The `cmd_op` codes are 0 START, 1 WRITE, 2 READ (one byte, answered with NACK) and 3 STOP.
- R4: The first write is 0x80 to register 0x0F. The next START comes at least the same delay as in R2 after that write's STOP, and it opens the write of 0x00 to 0x0F.
- R5: With `script_sel`=0 the writes as (register,data) are, in order: 0F/80, 0F/00, 52/CD, 00/00, 0E/80, 9C/00, 9C/FF, 0E/00, 17/41, 03/0C, 04/07, 13/00, 1D/40.
- R6: With `script_sel`=1 the writes are, in order: 0F/80, 0F/00, 52/CD, 00/05, 0C/37, 14/11, 02/54, 17/41, 03/0C, 04/07, 13/00, 1D/40.
- R7: With `readback_en`=1, each write's STOP is followed by START, WRITE 0x42, WRITE register, START, WRITE 0x43, READ, STOP. The 0x0F/0x80 write and all writes to 0x9C get no read-back.
- R8: With `readback_en`=0, no READ command is ever issued.
- R9: When a WRITE response carries `rsp_nack`=1, the block issues exactly one STOP and then nothing more. It raises `error` and sets `fail_idx` to the script entry index. Entries 0 and 2 are waits, the first write is entry 1, and write k≥1 is entry k+2.
- R10: A read-back value that differs from the value written sets `error` and `fail_idx` in the same way, once the read-back's STOP has been sent.
- R11: After the last write, `done` rises and stays high, `error` stays 0, and no further command is issued.
- R12: While `cmd_valid` is high and `cmd_ready` is low, `cmd_valid`, `cmd_op` and `cmd_byte` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| script_sel | input | 1 | 0 normal script, 1 free-run script; sampled once after reset |
| readback_en | input | 1 | Enables read-back and compare; sampled once after reset |
| cmd_valid | output | 1 | Command is valid |
| cmd_ready | input | 1 | Master accepts the command |
| cmd_op | output | 2 | 0 START, 1 WRITE, 2 READ with NACK, 3 STOP |
| cmd_byte | output | 8 | Byte to send for WRITE |
| rsp_valid | input | 1 | One-cycle response for the accepted command |
| rsp_nack | input | 1 | Slave did not acknowledge the WRITE byte |
| rsp_rdata | input | 8 | Byte returned by READ |
| done | output | 1 | Script completed |
| error | output | 1 | Script stopped on a failure |
| fail_idx | output | IDX_W | Script entry that failed |

## Verification
The bench runs both scripts, with read-back on and off and with and without ready stalls, and compares every command in order against a stream built from the register lists. A design that checked the clamp or soft-reset registers on read-back would stop with an error on a clean run. A design that skipped the wait after the soft reset would open the next START too early. A NACK is injected on each write in turn, and a bad read-back value on each checked read. A design that kept going, left the bus without a STOP, or counted entries wrongly would show a log that runs too long, or the wrong `fail_idx`.

// File: rtl/i2cseq_pkg.sv
package i2cseq_pkg;
  typedef enum logic [1:0] {OP_START = 2'd0, OP_WRITE = 2'd1, OP_READ = 2'd2, OP_STOP = 2'd3} i2c_op_e;
  typedef enum logic [1:0] {ENT_WRITE = 2'd0, ENT_DELAY = 2'd1, ENT_END = 2'd2} ent_kind_e;
  localparam int MS_W = 8;
  typedef struct packed {
    ent_kind_e       kind;
    logic            chk;
    logic [7:0]      reg_a;
    logic [7:0]      val;
    logic [MS_W-1:0] ms;
  } entry_t;
endpackage

// File: rtl/i2cseq_rom.sv
module i2cseq_rom
  import i2cseq_pkg::*;
#(
  parameter int IDX_W    = 4,
  parameter int DELAY_MS = 10
) (
  input  logic             sel_freerun,
  input  logic [IDX_W-1:0] idx,
  output entry_t           ent
);
  function automatic entry_t wr(input logic [7:0] r, input logic [7:0] v, input logic c);
    entry_t e;
    e.kind = ENT_WRITE; e.chk = c; e.reg_a = r; e.val = v; e.ms = '0;
    return e;
  endfunction

  function automatic entry_t dl(input logic [MS_W-1:0] m);
    entry_t e;
    e.kind = ENT_DELAY; e.chk = 1'b0; e.reg_a = '0; e.val = '0; e.ms = m;
    return e;
  endfunction

  function automatic entry_t fin();
    entry_t e;
    e.kind = ENT_END; e.chk = 1'b0; e.reg_a = '0; e.val = '0; e.ms = '0;
    return e;
  endfunction

  localparam logic [MS_W-1:0] WAIT_MS = MS_W'(DELAY_MS);

  int i;
  int tail_base;

  always_comb begin
    i = int'(idx);
    tail_base = sel_freerun ? 9 : 10;
    ent = fin();
    if (i < 5) begin
      case (i)
        0: ent = dl(WAIT_MS);
        1: ent = wr(8'h0F, 8'h80, 1'b0);
        2: ent = dl(WAIT_MS);
        3: ent = wr(8'h0F, 8'h00, 1'b1);
        default: ent = wr(8'h52, 8'hCD, 1'b1);
      endcase
    end else if (i < tail_base) begin
      if (!sel_freerun) begin
        case (i)
          5: ent = wr(8'h00, 8'h00, 1'b1);
          6: ent = wr(8'h0E, 8'h80, 1'b1);
          7: ent = wr(8'h9C, 8'h00, 1'b0);
          8: ent = wr(8'h9C, 8'hFF, 1'b0);
          default: ent = wr(8'h0E, 8'h00, 1'b1);
        endcase
      end else begin
        case (i)
          5: ent = wr(8'h00, 8'h05, 1'b1);
          6: ent = wr(8'h0C, 8'h37, 1'b1);
          7: ent = wr(8'h14, 8'h11, 1'b1);
          default: ent = wr(8'h02, 8'h54, 1'b1);
        endcase
      end
    end else begin
      case (i - tail_base)
        0: ent = wr(8'h17, 8'h41, 1'b1);
        1: ent = wr(8'h03, 8'h0C, 1'b1);
        2: ent = wr(8'h04, 8'h07, 1'b1);
        3: ent = wr(8'h13, 8'h00, 1'b1);
        4: ent = wr(8'h1D, 8'h40, 1'b1);
        default: ent = fin();
      endcase
    end
  end
endmodule

// File: rtl/i2cseq_ms_timer.sv
module i2cseq_ms_timer
  import i2cseq_pkg::*;
#(
  parameter int CLK_HZ = 27_000_000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [MS_W-1:0] ms,
  output logic            busy,
  output logic            expire
);
  localparam int TICK = (CLK_HZ / 1000 < 1) ? 1 : CLK_HZ / 1000;
  localparam int TW   = $clog2(TICK + 1);

  logic [TW-1:0]   cyc;
  logic [MS_W-1:0] left;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cyc <= '0; left <= '0; busy <= 1'b0; expire <= 1'b0;
    end else begin
      expire <= 1'b0;
      if (start) begin
        cyc <= '0;
        left <= ms;
        busy <= (ms != '0);
        expire <= (ms == '0);
      end else if (busy) begin
        if (cyc == TW'(TICK - 1)) begin
          cyc <= '0;
          if (left == MS_W'(1)) begin
            busy <= 1'b0;
            expire <= 1'b1;
          end else begin
            left <= left - 1'b1;
          end
        end else begin
          cyc <= cyc + 1'b1;
        end
      end
    end
  end

  assert_expire_after_wait_R2: assert property (@(posedge clk) disable iff (!rst_n)
    expire |-> ($past(busy) || $past(start)));
  assert_single_expire_R2: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> !expire);
endmodule

// File: rtl/i2cseq_frame.sv
module i2cseq_frame
  import i2cseq_pkg::*;
#(
  parameter logic [7:0] DEV_ADDR = 8'h42
) (
  input  logic [3:0] step,
  input  logic [7:0] reg_a,
  input  logic [7:0] val,
  output i2c_op_e    op,
  output logic [7:0] data
);
  always_comb begin
    op = OP_STOP;
    data = 8'h00;
    case (step)
      4'd0, 4'd5, 4'd8: op = OP_START;
      4'd1, 4'd6: begin op = OP_WRITE; data = DEV_ADDR; end
      4'd2, 4'd7: begin op = OP_WRITE; data = reg_a; end
      4'd3: begin op = OP_WRITE; data = val; end
      4'd9: begin op = OP_WRITE; data = DEV_ADDR | 8'h01; end
      4'd10: op = OP_READ;
      default: op = OP_STOP;
    endcase
  end
endmodule

// File: rtl/i2c_init_sequencer.sv
module i2c_init_sequencer
  import i2cseq_pkg::*;
#(
  parameter int         CLK_HZ   = 27_000_000,
  parameter int         DELAY_MS = 10,
  parameter int         IDX_W    = 4,
  parameter logic [7:0] DEV_ADDR = 8'h42
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             script_sel,
  input  logic             readback_en,
  output logic             cmd_valid,
  input  logic             cmd_ready,
  output logic [1:0]       cmd_op,
  output logic [7:0]       cmd_byte,
  input  logic             rsp_valid,
  input  logic             rsp_nack,
  input  logic [7:0]       rsp_rdata,
  output logic             done,
  output logic             error,
  output logic [IDX_W-1:0] fail_idx
);
  localparam logic [3:0] STEP_WR_STOP = 4'd4;
  localparam logic [3:0] STEP_RB_OPEN = 4'd5;
  localparam logic [3:0] STEP_RB_STOP = 4'd11;

  typedef enum logic [2:0] {S_BOOT, S_FETCH, S_DLY, S_ISSUE, S_WAIT, S_DONE, S_FAIL} st_e;

  st_e              state;
  logic [IDX_W-1:0] idx;
  logic [3:0]       step;
  logic             sel_q, rb_q, abort_q;
  entry_t           ent;
  i2c_op_e          fop;
  logic [7:0]       fbyte;
  logic             tmr_start, tmr_busy, tmr_exp;
  logic             bad;

  i2cseq_rom #(.IDX_W(IDX_W), .DELAY_MS(DELAY_MS)) u_rom (
    .sel_freerun(sel_q), .idx(idx), .ent(ent));

  i2cseq_ms_timer #(.CLK_HZ(CLK_HZ)) u_tmr (
    .clk(clk), .rst_n(rst_n), .start(tmr_start), .ms(ent.ms),
    .busy(tmr_busy), .expire(tmr_exp));

  i2cseq_frame #(.DEV_ADDR(DEV_ADDR)) u_frm (
    .step(step), .reg_a(ent.reg_a), .val(ent.val), .op(fop), .data(fbyte));

  assign tmr_start = (state == S_FETCH) && (ent.kind == ENT_DELAY);
  assign cmd_valid = (state == S_ISSUE);
  assign cmd_op    = fop;
  assign cmd_byte  = fbyte;
  assign bad = ((fop == OP_WRITE) && rsp_nack) || ((fop == OP_READ) && (rsp_rdata != ent.val));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_BOOT; idx <= '0; step <= '0; sel_q <= 1'b0; rb_q <= 1'b0;
      abort_q <= 1'b0; done <= 1'b0; error <= 1'b0; fail_idx <= '0;
    end else begin
      case (state)
        S_BOOT: begin
          sel_q <= script_sel;
          rb_q  <= readback_en;
          state <= S_FETCH;
        end
        S_FETCH: begin
          case (ent.kind)
            ENT_DELAY: state <= S_DLY;
            ENT_WRITE: begin step <= '0; state <= S_ISSUE; end
            default: begin done <= 1'b1; state <= S_DONE; end
          endcase
        end
        S_DLY: if (tmr_exp) begin idx <= idx + 1'b1; state <= S_FETCH; end
        S_ISSUE: if (cmd_ready) state <= S_WAIT;
        S_WAIT: if (rsp_valid) begin
          if (abort_q) begin
            state <= S_FAIL;
          end else if (bad) begin
            error <= 1'b1;
            fail_idx <= idx;
            abort_q <= 1'b1;
            step <= (step == 4'd10) ? STEP_RB_STOP : STEP_WR_STOP;
            state <= S_ISSUE;
          end else if (step == STEP_WR_STOP) begin
            if (rb_q && ent.chk) begin
              step <= STEP_RB_OPEN; state <= S_ISSUE;
            end else begin
              idx <= idx + 1'b1; state <= S_FETCH;
            end
          end else if (step == STEP_RB_STOP) begin
            idx <= idx + 1'b1; state <= S_FETCH;
          end else begin
            step <= step + 1'b1; state <= S_ISSUE;
          end
        end
        default: state <= state;
      endcase
    end
  end

  assert_hold_cmd_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_op) && $stable(cmd_byte)));
  assert_done_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!cmd_valid && !error));
  assert_error_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    error |=> (error && $stable(fail_idx) && !done));
  assert_no_read_when_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !rb_q) |-> (cmd_op != 2'd2));
  assert_done_once_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);
endmodule

// File: tb/sim_i2c_init_sequencer.sv
module sim_i2c_init_sequencer;
  localparam int CLK_HZ = 4000;
  localparam int DMS    = 2;
  localparam int NWAIT  = DMS * (CLK_HZ / 1000);

  logic clk = 0;
  logic rst_n = 0;
  logic script_sel = 0, readback_en = 0;
  logic cmd_valid, cmd_ready = 0;
  logic [1:0] cmd_op;
  logic [7:0] cmd_byte;
  logic rsp_valid = 0, rsp_nack = 0;
  logic [7:0] rsp_rdata = 0;
  logic done, error;
  logic [3:0] fail_idx;

  always #5 clk = ~clk;

  i2c_init_sequencer #(.CLK_HZ(CLK_HZ), .DELAY_MS(DMS)) u0 (
    .clk(clk), .rst_n(rst_n), .script_sel(script_sel), .readback_en(readback_en),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_byte(cmd_byte),
    .rsp_valid(rsp_valid), .rsp_nack(rsp_nack), .rsp_rdata(rsp_rdata),
    .done(done), .error(error), .fail_idx(fail_idx));

  int checks = 0, fails = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // slave model and log
  logic [1:0] lop [0:511];
  logic [7:0] lb  [0:511];
  int         lc  [0:511];
  int nlog = 0;
  logic [7:0] regs [0:255];
  int ph = 0, wcnt = 0, rcnt = 0, stall = 0, wait_cnt = 0;
  int nack_no = -1, corr_no = -1;
  logic [7:0] ptr = 0;
  logic [1:0] cap_op, hold_op;
  logic [7:0] cap_b, hold_b;

  always @(negedge clk) begin
    if (rsp_valid) begin rsp_valid = 0; rsp_nack = 0; end
    if (cmd_ready) begin
      cmd_ready = 0;
      if (nlog < 512) begin lop[nlog] = cap_op; lb[nlog] = cap_b; lc[nlog] = cyc; nlog++; end
      rsp_nack = 0; rsp_rdata = 0;
      case (cap_op)
        2'd0: ph = 1;
        2'd1: begin
          if (ph == 1) begin
            if (cap_b == 8'h42) ph = 2; else if (cap_b == 8'h43) ph = 4; else rsp_nack = 1;
          end else if (ph == 2) begin ptr = cap_b; ph = 3; end
          else if (ph == 3) begin
            if (wcnt == nack_no) rsp_nack = 1;
            else regs[ptr] = cap_b;
            wcnt++;
          end else rsp_nack = 1;
        end
        2'd2: begin
          if (ptr == 8'h9C) rsp_rdata = 8'h00;
          else if (ptr == 8'h0F) rsp_rdata = regs[ptr] & 8'h7F;
          else rsp_rdata = regs[ptr];
          if (rcnt == corr_no) rsp_rdata = rsp_rdata ^ 8'h01;
          rcnt++;
        end
        default: ph = 0;
      endcase
      rsp_valid = 1;
    end else if (rst_n && cmd_valid) begin
      if (wait_cnt > 0)
        chk(cmd_op == hold_op && cmd_byte == hold_b, "R12 held command", {cmd_op, cmd_byte}, {hold_op, hold_b});
      hold_op = cmd_op; hold_b = cmd_byte;
      if (wait_cnt < stall) wait_cnt++;
      else begin wait_cnt = 0; cmd_ready = 1; cap_op = cmd_op; cap_b = cmd_byte; end
    end
  end

  function automatic logic [15:0] exp_wr(input int sel, input int k);
    logic [15:0] n [0:12];
    logic [15:0] f [0:11];
    n = '{16'h0F80, 16'h0F00, 16'h52CD, 16'h0000, 16'h0E80, 16'h9C00, 16'h9CFF,
          16'h0E00, 16'h1741, 16'h030C, 16'h0407, 16'h1300, 16'h1D40};
    f = '{16'h0F80, 16'h0F00, 16'h52CD, 16'h0005, 16'h0C37, 16'h1411, 16'h0254,
          16'h1741, 16'h030C, 16'h0407, 16'h1300, 16'h1D40};
    return sel ? f[k] : n[k];
  endfunction

  function automatic int nwr(input int sel); return sel ? 12 : 13; endfunction
  function automatic logic verif(input int sel, input int k);
    logic [15:0] w = exp_wr(sel, k);
    return (k != 0) && (w[15:8] != 8'h9C);
  endfunction

  logic [1:0] eop [0:511];
  logic [7:0] eb  [0:511];
  int elen, efail;

  task automatic push(input logic [1:0] o, input logic [7:0] b);
    eop[elen] = o; eb[elen] = b; elen++;
  endtask

  task automatic build(input int sel, input int rb, input int nk, input int cr);
    int rd = 0;
    elen = 0; efail = -1;
    for (int k = 0; k < nwr(sel); k++) begin
      logic [15:0] w = exp_wr(sel, k);
      push(0, 0); push(1, 8'h42); push(1, w[15:8]); push(1, w[7:0]);
      if (k == nk) begin push(3, 0); efail = (k == 0) ? 1 : k + 2; return; end
      push(3, 0);
      if (rb != 0 && verif(sel, k)) begin
        push(0, 0); push(1, 8'h42); push(1, w[15:8]); push(0, 0); push(1, 8'h43); push(2, 0); push(3, 0);
        if (rd == cr) begin efail = (k == 0) ? 1 : k + 2; return; end
        rd++;
      end
    end
  endtask

  task automatic run(input int sel, input int rb, input int st, input int nk, input int cr);
    string tag;
    int n0, reads;
    tag = sel ? "R6" : "R5";
    if (nk >= 0) tag = "R9";
    if (cr >= 0) tag = "R10";
    @(negedge clk);
    rst_n = 0; script_sel = sel[0]; readback_en = rb[0]; stall = st;
    nack_no = nk; corr_no = cr;
    repeat (3) @(negedge clk);
    nlog = 0; wcnt = 0; rcnt = 0; ph = 0; wait_cnt = 0;
    for (int r = 0; r < 256; r++) regs[r] = 8'hEE;
    chk(!done && !error && !cmd_valid, "R1 state in reset", {done, error, cmd_valid}, 0);
    rst_n = 1;
    n0 = cyc;
    @(negedge clk);
    chk(!done && !error && !cmd_valid, "R1 state after release", {done, error, cmd_valid}, 0);
    for (int t = 0; t < 5000 && !done && !error; t++) @(negedge clk);
    repeat (5) @(negedge clk);
    begin
      int keep = nlog;
      repeat (20) @(negedge clk);
      chk(nlog == keep, "R11 R9 no commands after end", nlog, keep);
    end
    build(sel, rb, nk, cr);
    if (efail < 0) begin
      chk(done && !error, "R11 done raised", {done, error}, 2);
    end else begin
      chk(error && !done, {tag, " error raised"}, {done, error}, 1);
      chk(int'(fail_idx) == efail, {tag, " fail index"}, fail_idx, efail);
    end
    chk(nlog == elen, {tag, " command count"}, nlog, elen);
    for (int i = 0; i < elen && i < nlog; i++) begin
      string t2 = (i < 5) ? "R3" : ((i >= 10 && i < 17 && rb != 0) ? "R7" : tag);
      chk(lop[i] == eop[i] && (eop[i] != 2'd1 || lb[i] == eb[i]),
          $sformatf("%s command %0d", t2, i), {lop[i], lb[i]}, {eop[i], eb[i]});
    end
    if (nlog > 0)
      chk(lc[0] - n0 >= NWAIT && lc[0] - n0 <= NWAIT + 10, "R2 first command time", lc[0] - n0, NWAIT);
    if (nlog > 5)
      chk(lc[5] - lc[4] >= NWAIT && lb[7] == 8'h0F && lb[8] == 8'h00, "R4 wait after soft reset",
          lc[5] - lc[4], NWAIT);
    reads = 0;
    for (int i = 0; i < nlog; i++) if (lop[i] == 2'd2) reads++;
    if (rb == 0) chk(reads == 0, "R8 no reads", reads, 0);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    for (int s = 0; s < 2; s++)
      for (int rb = 0; rb < 2; rb++)
        for (int st = 0; st < 4; st += 3)
          run(s, rb, st, -1, -1);
    for (int s = 0; s < 2; s++)
      for (int k = 0; k < nwr(s); k++)
        run(s, 1, 1, k, -1);
    for (int s = 0; s < 2; s++)
      for (int r = 0; r < (s ? 11 : 10); r++)
        run(s, 1, 0, -1, r);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(10 * 190000);
    checks++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule